// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup with Fault Reporting

This block translates a virtual address into a physical page frame. It uses a translation cache that is set-associative, with a fixed number of ways and a fixed number of indexes. There is one array for instruction fetches and one for data accesses. Each request carries an address, an access kind (read, write or execute), a user-mode flag, a debug flag and the current process tag. One cycle later the block reports whether the translation succeeded, the physical frame, the granted read/write/execute rights and an exception vector number. When the lookup fails, the vector number tells the handler which kind of fault occurred.

When a non-debug request faults, the block latches two values. The refill-select value gives the index and the way that software should refill. The cause value gives the page number, the access kind and the process tag. On a miss the way comes from a 16-bit linear feedback shift register. That register advances once per non-debug fault, so replacement is spread across the ways. Software loads entries through a plain write port, and a write has precedence over a lookup issued in the same cycle.

Top module: `tlb_lookup_unit`

## Requirements
- R1: Pages are 8 KB. The page number is address bits [31:13], and the index is page-number bits [3:0]. On a hit, `rsp_pfn_o` carries bits [31:13] of the matched low word. When the access is not a hit, it reads zero.
- R2: An entry hits when its tag-word bits [31:13] equal the page number and, in addition, either its global bit is set or its tag-word bits [7:0] equal `req_pid_i`. When several ways hit, the lowest-numbered way wins.
- R3: A write with `wr_en_i` stores `wr_hi_i` and `wr_lo_i` at (`wr_itlb_i`, `wr_way_i`, `wr_idx_i`). `wr_itlb_i`=1 selects the instruction array. The low-word layout is: frame [31:13], global bit 4, valid bit 3, kernel bit 2, writable bit 1, executable bit 0.
- R4: Faults on a matched entry are ranked in this order. First, a kernel page in user mode with the kernel check on gives base+2. Next, a write to a page that is not writable with the write check on gives base+3. Next, an execute of a page that is not executable with the exec check on gives base+3. Last, an entry that is not valid with the valid check on gives base+1. A miss gives base+0, and a hit also reports base.
- R5: Kind 2 (execute) looks up the instruction array with base 4. Kinds 0 (read) and 1 (write) look up the data array with base 8. Kind 3 behaves as a read.
- R6: On a hit, `rsp_prot_o` = {exec, write, read}. Read is 1 and write equals the entry's writable bit. Exec is 1 only for the instruction array and only when the exec check is on or the entry's executable bit is set. On a fault, `rsp_prot_o` is 0 and `rsp_hit_o` is 0.
- R7: A non-debug fault loads `sel_o` with the index in [3:0] and the way in [5:4]. It also loads `cause_o` with the page number in [31:13], the kind in [9:8] (kind 3 reported as 0), the process tag in [7:0] and zeros elsewhere. On a miss the way is the register's low 2 bits. On a protection fault it is the matched way.
- R8: The register resets to 0xCCCC. On each non-debug fault it shifts right by one and puts into bit 15 the parity of the state ANDed with 0x8805. The victim way is taken before the shift, so the first two misses after reset name ways 0 and 2.
- R9: A request with `req_debug_i` set still returns a full response. It leaves `sel_o`, `cause_o` and the shift register unchanged.
- R10: `rsp_valid_o` rises in the cycle after an accepted request, and the result fields update in that same cycle.
- R11: A write and a request in the same cycle perform the write and drop the request, so no response follows. The written entry is visible to a request in the next cycle.
- R12: After reset all outputs are zero, and every stored word is zero.
- R13: `chk_en_i` enables the checks: bit 3 write, bit 2 kernel, bit 1 exec, bit 0 valid. With a check off, its fault is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| chk_en_i | input | 4 | Check enables {write, kernel, exec, valid} |
| wr_en_i | input | 1 | Entry write strobe |
| wr_itlb_i | input | 1 | Write target: 1 instruction array, 0 data array |
| wr_way_i | input | 2 | Way being written |
| wr_idx_i | input | 4 | Index being written |
| wr_hi_i | input | 32 | Tag word (page number, process tag) |
| wr_lo_i | input | 32 | Frame and attribute word |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0 read, 1 write, 2 execute |
| req_user_i | input | 1 | Access made in user mode |
| req_debug_i | input | 1 | Side-effect-free lookup |
| req_pid_i | input | 8 | Current process tag |
| rsp_valid_o | output | 1 | Result present |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_pfn_o | output | 19 | Physical frame number |
| rsp_prot_o | output | 3 | Granted {exec, write, read} |
| rsp_vec_o | output | 4 | Exception vector number |
| sel_o | output | 6 | Refill select {way, index} |
| cause_o | output | 32 | Fault cause word |

## Verification
The first directed patterns separate two effects: matching on the process tag versus the global bit, and the lowest-way winner when two ways hold the same page. The protection patterns give one entry several fault conditions at once and then switch checks off one at a time, which exposes the fault ranking and each enable bit. Misses from reset pin down the shift-register seed and the order of its update. Debug faults and write-versus-request collisions show that no side effect leaks through. A long random phase over a small page space then mixes hits, misses, refills and every check setting against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // access kinds
   localparam logic [1:0] ACC_READ  = 2'd0;
   localparam logic [1:0] ACC_WRITE = 2'd1;
   localparam logic [1:0] ACC_EXEC  = 2'd2;

   // attribute bit positions inside the low word
   localparam int LO_GLB = 4;
   localparam int LO_VLD = 3;
   localparam int LO_KRN = 2;
   localparam int LO_WR  = 1;
   localparam int LO_EX  = 0;

   // check enable bit positions
   localparam int CHK_WR  = 3;
   localparam int CHK_KRN = 2;
   localparam int CHK_EX  = 1;
   localparam int CHK_VLD = 0;

   // vector bases and offsets
   localparam logic [3:0] VEC_BASE_I = 4'd4;
   localparam logic [3:0] VEC_BASE_D = 4'd8;
   localparam logic [1:0] OFF_MISS   = 2'd0;
   localparam logic [1:0] OFF_INVAL  = 2'd1;
   localparam logic [1:0] OFF_KERNEL = 2'd2;
   localparam logic [1:0] OFF_RIGHTS = 2'd3;

   // field position of the access kind in the cause word
   localparam int CAUSE_KIND_LSB = 8;

   function automatic logic [1:0] norm_kind(input logic [1:0] k);
      return (k == 2'd3) ? ACC_READ : k;
   endfunction
endpackage

// File: rtl/tlb_way_array.sv
module tlb_way_array #(
   parameter int NUM_IDX = 16,
   parameter int WORD_W  = 32,
   localparam int IDX_W  = $clog2(NUM_IDX)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              wr_itlb_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_hi_i,
   input  logic [WORD_W-1:0] wr_lo_i,
   input  logic              rd_itlb_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0] rd_hi_o,
   output logic [WORD_W-1:0] rd_lo_o
);
   // index 0: data array, index 1: instruction array
   logic [WORD_W-1:0] hi_q [2][NUM_IDX];
   logic [WORD_W-1:0] lo_q [2][NUM_IDX];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int a = 0; a < 2; a++) begin
            for (int i = 0; i < NUM_IDX; i++) begin
               hi_q[a][i] <= '0;
               lo_q[a][i] <= '0;
            end
         end
      end else if (wr_en_i) begin
         hi_q[wr_itlb_i][wr_idx_i] <= wr_hi_i;
         lo_q[wr_itlb_i][wr_idx_i] <= wr_lo_i;
      end
   end

   assign rd_hi_o = hi_q[rd_itlb_i][rd_idx_i];
   assign rd_lo_o = lo_q[rd_itlb_i][rd_idx_i];
endmodule

// File: rtl/tlb_tag_match.sv
module tlb_tag_match
   import tlb_pkg::*;
#(
   parameter int NUM_WAYS  = 4,
   parameter int WORD_W    = 32,
   parameter int PAGE_BITS = 13,
   parameter int PID_W     = 8,
   localparam int VPN_W    = WORD_W - PAGE_BITS,
   localparam int WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic [VPN_W-1:0]                 vpn_i,
   input  logic [PID_W-1:0]                 pid_i,
   input  logic [NUM_WAYS-1:0][WORD_W-1:0]  hi_i,
   input  logic [NUM_WAYS-1:0][WORD_W-1:0]  lo_i,
   output logic                             hit_o,
   output logic [WAY_W-1:0]                 way_o,
   output logic [WORD_W-1:0]                lo_o
);
   logic [NUM_WAYS-1:0] way_hit;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      logic tag_eq, owner_ok;
      assign tag_eq   = (hi_i[w][WORD_W-1:PAGE_BITS] == vpn_i);
      assign owner_ok = lo_i[w][LO_GLB] | (hi_i[w][PID_W-1:0] == pid_i);
      assign way_hit[w] = tag_eq & owner_ok;
   end

   // lowest-numbered way wins
   always_comb begin
      way_o = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (way_hit[w]) way_o = WAY_W'(w);
      end
   end

   assign hit_o = |way_hit;
   assign lo_o  = lo_i[way_o];
endmodule

// File: rtl/tlb_fault_eval.sv
module tlb_fault_eval
   import tlb_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              hit_i,
   input  logic [WORD_W-1:0] lo_i,
   input  logic [1:0]        kind_i,
   input  logic              user_i,
   input  logic [3:0]        chk_i,
   output logic              ok_o,
   output logic [1:0]        off_o,
   output logic [2:0]        prot_o
);
   logic is_exec, is_write;
   assign is_exec  = (kind_i == ACC_EXEC);
   assign is_write = (kind_i == ACC_WRITE);

   always_comb begin
      ok_o   = 1'b0;
      off_o  = OFF_MISS;
      prot_o = 3'b000;
      if (hit_i) begin
         if (chk_i[CHK_KRN] && lo_i[LO_KRN] && user_i) begin
            off_o = OFF_KERNEL;
         end else if (is_write && chk_i[CHK_WR] && !lo_i[LO_WR]) begin
            off_o = OFF_RIGHTS;
         end else if (is_exec && chk_i[CHK_EX] && !lo_i[LO_EX]) begin
            off_o = OFF_RIGHTS;
         end else if (chk_i[CHK_VLD] && !lo_i[LO_VLD]) begin
            off_o = OFF_INVAL;
         end else begin
            ok_o   = 1'b1;
            prot_o = {is_exec & (chk_i[CHK_EX] | lo_i[LO_EX]), lo_i[LO_WR], 1'b1};
         end
      end
   end
endmodule

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr #(
   parameter int          LFSR_W = 16,
   parameter logic [15:0] SEED   = 16'hCCCC,
   parameter logic [15:0] TAPS   = 16'h8805
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   output logic [LFSR_W-1:0] state_o
);
   logic [LFSR_W-1:0] state_q;
   logic              fb;

   assign fb = ^(state_q & TAPS[LFSR_W-1:0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     state_q <= SEED[LFSR_W-1:0];
      else if (adv_i)  state_q <= {fb, state_q[LFSR_W-1:1]};
   end

   assign state_o = state_q;

   // R8
   lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(state_q));

   // R8
   lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |=> (state_q != '0));
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
   import tlb_pkg::*;
#(
   parameter int          NUM_WAYS  = 4,
   parameter int          NUM_IDX   = 16,
   parameter int          VA_W      = 32,
   parameter int          PAGE_BITS = 13,
   parameter int          PID_W     = 8,
   parameter int          LFSR_W    = 16,
   parameter logic [15:0] LFSR_SEED = 16'hCCCC,
   parameter logic [15:0] LFSR_TAPS = 16'h8805,
   localparam int VPN_W = VA_W - PAGE_BITS,
   localparam int IDX_W = $clog2(NUM_IDX),
   localparam int WAY_W = $clog2(NUM_WAYS),
   localparam int SEL_W = IDX_W + WAY_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [3:0]       chk_en_i,
   input  logic             wr_en_i,
   input  logic             wr_itlb_i,
   input  logic [WAY_W-1:0] wr_way_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [VA_W-1:0]  wr_hi_i,
   input  logic [VA_W-1:0]  wr_lo_i,
   input  logic             req_valid_i,
   input  logic [VA_W-1:0]  req_vaddr_i,
   input  logic [1:0]       req_kind_i,
   input  logic             req_user_i,
   input  logic             req_debug_i,
   input  logic [PID_W-1:0] req_pid_i,
   output logic             rsp_valid_o,
   output logic             rsp_hit_o,
   output logic [VPN_W-1:0] rsp_pfn_o,
   output logic [2:0]       rsp_prot_o,
   output logic [3:0]       rsp_vec_o,
   output logic [SEL_W-1:0] sel_o,
   output logic [VA_W-1:0]  cause_o
);
   // elaboration-time parameter checks
   if ((NUM_WAYS < 2) || ((1 << WAY_W) != NUM_WAYS)) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if ((NUM_IDX < 2) || ((1 << IDX_W) != NUM_IDX)) begin : g_bad_idx
      $error("NUM_IDX must be a power of two of at least 2");
   end
   if (PAGE_BITS < CAUSE_KIND_LSB + 2) begin : g_bad_page
      $error("PAGE_BITS too small for the cause layout");
   end
   if (PID_W > CAUSE_KIND_LSB) begin : g_bad_pid
      $error("PID_W overlaps the cause kind field");
   end
   if ((LFSR_W > 16) || (LFSR_W < WAY_W)) begin : g_bad_lfsr
      $error("LFSR_W out of range");
   end
   if (IDX_W > VPN_W) begin : g_bad_vpn
      $error("index wider than page number");
   end

   // request decode
   logic             fire;
   logic [1:0]       kind;
   logic             use_itlb;
   logic [VPN_W-1:0] vpn;
   logic [IDX_W-1:0] idx;

   assign fire     = req_valid_i & ~wr_en_i;
   assign kind     = norm_kind(req_kind_i);
   assign use_itlb = (kind == ACC_EXEC);
   assign vpn      = req_vaddr_i[VA_W-1:PAGE_BITS];
   assign idx      = vpn[IDX_W-1:0];

   // storage, one instance per way
   logic [NUM_WAYS-1:0][VA_W-1:0] way_hi;
   logic [NUM_WAYS-1:0][VA_W-1:0] way_lo;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic way_we;
      assign way_we = wr_en_i & (wr_way_i == WAY_W'(w));
      tlb_way_array #(
         .NUM_IDX (NUM_IDX),
         .WORD_W  (VA_W)
      ) u_store (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .wr_en_i   (way_we),
         .wr_itlb_i (wr_itlb_i),
         .wr_idx_i  (wr_idx_i),
         .wr_hi_i   (wr_hi_i),
         .wr_lo_i   (wr_lo_i),
         .rd_itlb_i (use_itlb),
         .rd_idx_i  (idx),
         .rd_hi_o   (way_hi[w]),
         .rd_lo_o   (way_lo[w])
      );
   end

   // tag compare
   logic             tag_hit;
   logic [WAY_W-1:0] tag_way;
   logic [VA_W-1:0]  tag_lo;

   tlb_tag_match #(
      .NUM_WAYS  (NUM_WAYS),
      .WORD_W    (VA_W),
      .PAGE_BITS (PAGE_BITS),
      .PID_W     (PID_W)
   ) u_match (
      .vpn_i (vpn),
      .pid_i (req_pid_i),
      .hi_i  (way_hi),
      .lo_i  (way_lo),
      .hit_o (tag_hit),
      .way_o (tag_way),
      .lo_o  (tag_lo)
   );

   // protection evaluation
   logic       acc_ok;
   logic [1:0] vec_off;
   logic [2:0] prot;

   tlb_fault_eval #(
      .WORD_W (VA_W)
   ) u_fault (
      .hit_i  (tag_hit),
      .lo_i   (tag_lo),
      .kind_i (kind),
      .user_i (req_user_i),
      .chk_i  (chk_en_i),
      .ok_o   (acc_ok),
      .off_o  (vec_off),
      .prot_o (prot)
   );

   // victim selection
   logic              lfsr_adv;
   logic [LFSR_W-1:0] lfsr_state;

   assign lfsr_adv = fire & ~acc_ok & ~req_debug_i;

   tlb_victim_lfsr #(
      .LFSR_W (LFSR_W),
      .SEED   (LFSR_SEED),
      .TAPS   (LFSR_TAPS)
   ) u_lfsr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (lfsr_adv),
      .state_o (lfsr_state)
   );

   logic [WAY_W-1:0] fault_way;
   logic [3:0]       vec;
   logic [VA_W-1:0]  cause_d;

   assign fault_way = tag_hit ? tag_way : lfsr_state[WAY_W-1:0];
   assign vec       = (use_itlb ? VEC_BASE_I : VEC_BASE_D) + {2'b00, vec_off};

   always_comb begin
      cause_d = '0;
      cause_d[VA_W-1:PAGE_BITS]                  = vpn;
      cause_d[CAUSE_KIND_LSB +: 2]               = kind;
      cause_d[PID_W-1:0]                         = req_pid_i;
   end

   // result and fault registers
   logic             rsp_valid_q, rsp_hit_q;
   logic [VPN_W-1:0] rsp_pfn_q;
   logic [2:0]       rsp_prot_q;
   logic [3:0]       rsp_vec_q;
   logic [SEL_W-1:0] sel_q;
   logic [VA_W-1:0]  cause_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_pfn_q   <= '0;
         rsp_prot_q  <= '0;
         rsp_vec_q   <= '0;
      end else begin
         rsp_valid_q <= fire;
         if (fire) begin
            rsp_hit_q  <= acc_ok;
            rsp_pfn_q  <= acc_ok ? tag_lo[VA_W-1:PAGE_BITS] : '0;
            rsp_prot_q <= prot;
            rsp_vec_q  <= vec;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q   <= '0;
         cause_q <= '0;
      end else if (lfsr_adv) begin
         sel_q   <= {fault_way, idx};
         cause_q <= cause_d;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_hit_o   = rsp_hit_q;
   assign rsp_pfn_o   = rsp_pfn_q;
   assign rsp_prot_o  = rsp_prot_q;
   assign rsp_vec_o   = rsp_vec_q;
   assign sel_o       = sel_q;
   assign cause_o     = cause_q;

   // R10
   rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !wr_en_i) |=> rsp_valid_o);

   // R11
   write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !rsp_valid_o);

   // R6
   hit_grants_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_hit_o) |-> rsp_prot_o[0]);

   // R6
   fault_no_rights_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_hit_o) |-> (rsp_prot_o == 3'b000));

   // R5
   data_no_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_vec_o[3]) |-> !rsp_prot_o[2]);

   // R9
   debug_no_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_debug_i) |=> ($stable(cause_o) && $stable(sel_o)));

   // R1
   miss_zero_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_hit_o) |-> (rsp_pfn_o == '0));
endmodule

// File: tb/tlb_lookup_unit_tb.sv
module tlb_lookup_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  chk_en = '0;
   logic        wr_en = 1'b0, wr_itlb = 1'b0;
   logic [1:0]  wr_way = '0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_hi = '0, wr_lo = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0, req_debug = 1'b0;
   logic [7:0]  req_pid = '0;

   logic        rsp_valid, rsp_hit;
   logic [18:0] rsp_pfn;
   logic [2:0]  rsp_prot;
   logic [3:0]  rsp_vec;
   logic [5:0]  sel;
   logic [31:0] cause;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_lookup_unit u_dut (
      .clk_i(clk), .rst_ni(rst_n), .chk_en_i(chk_en),
      .wr_en_i(wr_en), .wr_itlb_i(wr_itlb), .wr_way_i(wr_way), .wr_idx_i(wr_idx),
      .wr_hi_i(wr_hi), .wr_lo_i(wr_lo),
      .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_kind_i(req_kind),
      .req_user_i(req_user), .req_debug_i(req_debug), .req_pid_i(req_pid),
      .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pfn_o(rsp_pfn),
      .rsp_prot_o(rsp_prot), .rsp_vec_o(rsp_vec), .sel_o(sel), .cause_o(cause)
   );

   int checks = 0;
   int failures = 0;

   // behavioural reference state
   logic [31:0] m_hi [2][4][16];
   logic [31:0] m_lo [2][4][16];
   logic [15:0] m_lfsr;
   logic        e_valid, e_hit;
   logic [18:0] e_pfn;
   logic [2:0]  e_prot;
   logic [3:0]  e_vec;
   logic [5:0]  e_sel;
   logic [31:0] e_cause;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int a = 0; a < 2; a++)
         for (int s = 0; s < 4; s++)
            for (int i = 0; i < 16; i++) begin
               m_hi[a][s][i] = '0;
               m_lo[a][s][i] = '0;
            end
      m_lfsr = 16'hCCCC;
      e_valid = 0; e_hit = 0; e_pfn = '0; e_prot = '0; e_vec = '0; e_sel = '0; e_cause = '0;
   endtask

   // model of one clock edge using the inputs currently driven
   task automatic model_step();
      if (wr_en) begin
         m_hi[wr_itlb][wr_way][wr_idx] = wr_hi;   // R3 / R11: write taken, request dropped
         m_lo[wr_itlb][wr_way][wr_idx] = wr_lo;
         e_valid = 0;
      end else if (req_valid) begin
         int k, arr, found, off, idx, way;
         logic [18:0] vpn;
         logic [31:0] lo;
         bit ok;
         k     = (req_kind == 2'd3) ? 0 : int'(req_kind);
         arr   = (k == 2) ? 1 : 0;
         vpn   = req_vaddr[31:13];
         idx   = int'(vpn[3:0]);
         found = -1;
         for (int s = 0; s < 4; s++)
            if (found < 0 && m_hi[arr][s][idx][31:13] == vpn &&
                (m_lo[arr][s][idx][4] || m_hi[arr][s][idx][7:0] == req_pid))
               found = s;
         ok = 0; off = 0; lo = '0;
         e_prot = 3'b000;
         if (found >= 0) begin
            lo = m_lo[arr][found][idx];
            if (chk_en[2] && lo[2] && req_user) off = 2;
            else if (k == 1 && chk_en[3] && !lo[1]) off = 3;
            else if (k == 2 && chk_en[1] && !lo[0]) off = 3;
            else if (chk_en[0] && !lo[3]) off = 1;
            else begin
               ok = 1;
               e_prot = {(arr == 1) && (chk_en[1] || lo[0]), lo[1], 1'b1};
            end
         end
         e_valid = 1;
         e_hit   = ok;
         e_pfn   = ok ? lo[31:13] : '0;
         e_vec   = 4'((arr == 1 ? 4 : 8) + off);
         if (!ok && !req_debug) begin
            way     = (found >= 0) ? found : int'(m_lfsr[1:0]);
            e_sel   = {2'(way), 4'(idx)};
            e_cause = {vpn, 3'b000, 2'(k), req_pid};
            m_lfsr  = {^(m_lfsr & 16'h8805), m_lfsr[15:1]};
         end
      end else begin
         e_valid = 0;
      end
   endtask

   task automatic compare_all();
      check(rsp_valid == e_valid, "R10 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      if (e_valid) begin
         check(rsp_hit == e_hit, "R2 hit", 32'(rsp_hit), 32'(e_hit));
         check(rsp_pfn == e_pfn, "R1 pfn", 32'(rsp_pfn), 32'(e_pfn));
         check(rsp_prot == e_prot, "R6 prot", 32'(rsp_prot), 32'(e_prot));
         check(rsp_vec == e_vec, "R4 vec", 32'(rsp_vec), 32'(e_vec));
      end
      check(sel == e_sel, "R7 sel", 32'(sel), 32'(e_sel));
      check(cause == e_cause, "R7 cause", cause, e_cause);
   endtask

   task automatic cycle();
      model_step();
      @(posedge clk);
      #1;
      compare_all();
      wr_en = 0;
      req_valid = 0;
   endtask

   task automatic do_write(input bit itlb, input int way, input int idx, input logic [31:0] hi, input logic [31:0] lo);
      wr_en = 1; wr_itlb = itlb; wr_way = 2'(way); wr_idx = 4'(idx); wr_hi = hi; wr_lo = lo;
      cycle();
   endtask

   task automatic do_look(input logic [31:0] va, input int kind, input bit user, input bit dbg, input logic [7:0] pid);
      req_valid = 1; req_vaddr = va; req_kind = 2'(kind); req_user = user; req_debug = dbg; req_pid = pid;
      cycle();
   endtask

   function automatic logic [31:0] mk_hi(input logic [18:0] vpn, input logic [7:0] pid);
      return {vpn, 5'b0, pid};
   endfunction
   // lo: frame, global(4), valid(3), kernel(2), writable(1), executable(0)
   function automatic logic [31:0] mk_lo(input logic [18:0] pfn, input logic [4:0] attr);
      return {pfn, 8'b0, attr};
   endfunction

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      check({rsp_valid, rsp_hit, rsp_pfn, rsp_prot, rsp_vec} == '0, "R12 rsp reset", 32'(rsp_pfn), 0);
      check(sel == '0 && cause == '0, "R12 sel/cause reset", cause, 0);
      rst_n = 1;
      @(negedge clk);

      // R8: first misses from reset name ways 0 then 2
      chk_en = 4'b0000;
      do_look(32'h0002_2000, 0, 0, 0, 8'h01);
      check(sel == 6'h01, "R8 first victim", 32'(sel), 32'h01);
      do_look(32'h0002_2000, 1, 0, 0, 8'h01);
      check(sel == 6'h21, "R8 second victim", 32'(sel), 32'h21);
      check(cause == 32'h0002_2101, "R7 cause layout", cause, 32'h0002_2101);

      // R12: zero entries match page 0 / tag 0, invalid with valid check
      chk_en = 4'b0001;
      do_look(32'h0000_0000, 0, 0, 0, 8'h00);
      check(rsp_vec == 4'd9, "R12 zero entry invalid", 32'(rsp_vec), 9);

      // R3: load entries
      do_write(0, 1, 5, mk_hi(19'h00025, 8'h11), mk_lo(19'h01234, 5'b01010));
      do_write(0, 2, 5, mk_hi(19'h00035, 8'h00), mk_lo(19'h04321, 5'b11100));
      do_write(1, 3, 5, mk_hi(19'h00045, 8'h11), mk_lo(19'h00777, 5'b00000));
      do_write(1, 0, 6, mk_hi(19'h00046, 8'h11), mk_lo(19'h00888, 5'b01001));

      // R2: tag match and global
      chk_en = 4'b1111;
      do_look(32'h0004_A000, 0, 0, 0, 8'h11);
      check(rsp_hit && rsp_pfn == 19'h01234, "R2 pid hit", 32'(rsp_pfn), 32'h1234);
      do_look(32'h0004_A000, 0, 0, 0, 8'h22);
      check(!rsp_hit && rsp_vec == 4'd8, "R2 pid mismatch miss", 32'(rsp_vec), 8);
      do_look(32'h0006_A000, 0, 0, 0, 8'h77);
      check(rsp_hit, "R2 global hit", 32'(rsp_hit), 1);
      // R4: kernel page in user mode, outranks write fault
      do_look(32'h0006_A000, 1, 1, 0, 8'h77);
      check(rsp_vec == 4'd10 && sel == 6'h25, "R4 kernel fault, R7 matched way", 32'(sel), 32'h25);
      do_look(32'h0006_A000, 1, 0, 0, 8'h77);
      check(rsp_vec == 4'd11, "R4 write fault", 32'(rsp_vec), 11);
      // R13: write check off lets the write through
      chk_en = 4'b0111;
      do_look(32'h0006_A000, 1, 1, 0, 8'h77);
      check(rsp_vec == 4'd10, "R13 kernel still checked", 32'(rsp_vec), 10);
      chk_en = 4'b0011;
      do_look(32'h0006_A000, 1, 1, 0, 8'h77);
      check(rsp_hit && rsp_prot == 3'b001, "R13 checks off hit", 32'(rsp_prot), 1);

      // R5 / R4: instruction array
      chk_en = 4'b0011;
      do_look(32'h0008_A000, 2, 0, 0, 8'h11);
      check(rsp_vec == 4'd7, "R4 exec fault", 32'(rsp_vec), 7);
      chk_en = 4'b0001;
      do_look(32'h0008_A000, 2, 0, 0, 8'h11);
      check(rsp_vec == 4'd5, "R4 invalid fault", 32'(rsp_vec), 5);
      chk_en = 4'b0000;
      do_look(32'h0008_A000, 2, 0, 0, 8'h11);
      check(rsp_hit && rsp_prot == 3'b001, "R6 no exec right", 32'(rsp_prot), 1);
      chk_en = 4'b0010;
      do_look(32'h0008_C000, 2, 0, 0, 8'h11);
      check(rsp_prot == 3'b101, "R6 exec right", 32'(rsp_prot), 5);
      do_look(32'h0008_A000, 0, 0, 0, 8'h11);
      check(!rsp_hit && rsp_vec == 4'd8, "R5 read uses data array", 32'(rsp_vec), 8);

      // R2: duplicate page in a lower way wins
      do_write(0, 0, 5, mk_hi(19'h00025, 8'h11), mk_lo(19'h05555, 5'b01011));
      do_look(32'h0004_A000, 3, 0, 0, 8'h11);
      check(rsp_pfn == 19'h05555, "R2 lowest way", 32'(rsp_pfn), 32'h5555);

      // R9: debug miss has no side effect
      do_look(32'h1000_0000, 0, 0, 1, 8'h33);
      check(rsp_valid && !rsp_hit, "R9 debug response", 32'(rsp_hit), 0);
      do_look(32'h1000_0000, 0, 0, 0, 8'h33);

      // R11: write and request together
      req_valid = 1; req_vaddr = 32'h0004_A000; req_kind = 0; req_pid = 8'h11; req_debug = 0;
      wr_en = 1; wr_itlb = 0; wr_way = 0; wr_idx = 5;
      wr_hi = mk_hi(19'h00025, 8'h11); wr_lo = mk_lo(19'h06666, 5'b01010);
      cycle();
      check(!rsp_valid, "R11 request dropped", 32'(rsp_valid), 0);
      do_look(32'h0004_A000, 0, 0, 0, 8'h11);
      check(rsp_pfn == 19'h06666, "R11 write visible", 32'(rsp_pfn), 32'h6666);

      // random mix against the model
      for (int n = 0; n < 3000; n++) begin
         logic [18:0] vpn;
         int r;
         r = int'($urandom_range(0, 99));
         vpn = {13'b0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3))};
         chk_en = 4'($urandom_range(0, 15));
         if (r < 20) begin
            do_write(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), int'(vpn[3:0]),
                     mk_hi(vpn, ($urandom_range(0, 1) != 0) ? 8'h11 : 8'h22),
                     mk_lo(19'($urandom), 5'($urandom_range(0, 31))));
         end else if (r < 90) begin
            do_look({vpn, 13'($urandom)}, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 9) == 0), ($urandom_range(0, 1) != 0) ? 8'h11 : 8'h22);
         end else begin
            cycle();
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule